// File: doc/BRIEF.md
# Write Data Lane Steering Unit

This block sits between an internal write path and an external data bus that is split into four byte lanes. It accepts one write request at a time and places the operand bytes on the lanes that the external memory expects. The request gives a size code, the two lowest address bits, a 32-bit write word and the width of the target port. Byte and halfword operands are copied onto several lanes in a fixed pattern. Every lane that a write does not use has its drive enable held low.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no external transaction is pending, so the requester must hold its fields steady until the handshake. Each external transaction is shown on `ext_valid` and stays unchanged until the bus side answers with `ext_done`. When a 32-bit word goes to a 16-bit port, the block issues two ordered transactions. It raises `ext_atomic` for the whole pair so that bus arbitration cannot hand the bus away between them. A request with a size and offset pair that is not allowed is rejected with a one-cycle `req_illegal` pulse, and no transaction follows.

Lane numbering follows the bus: lane D[0:7] carries the most significant byte and maps to `ext_data[31:24]` and `ext_lane_en[3]`. Lane D[24:31] maps to `ext_data[7:0]` and `ext_lane_en[0]`. Operand byte OP0 is `req_data[31:24]` and OP3 is `req_data[7:0]`. `ext_addr_lo[1]` is address bit A30 and `ext_addr_lo[0]` is A31.

Top module: `wr_lane_steer`

## Requirements
- R1: `req_size` encodes byte as 01, halfword as 10 and word as 00. A request with size 11, a halfword at an odd offset, or a word at any offset other than 00 gives `req_illegal` high for exactly the cycle after acceptance, produces no transaction, and leaves `req_ready` high.
- R2: On a 32-bit port, a byte write at offset 00 drives OP0 on D[0:7] only (enable 1000). Offset 01 drives OP1 on D[0:7] and D[8:15] (1100). Offset 10 drives OP2 on D[0:7] and D[16:23] (1010). Offset 11 drives OP3 on D[0:7], D[8:15] and D[24:31] (1101).
- R3: On a 32-bit port, a halfword at offset 00 drives OP0,OP1 on D[0:15] (1100). At offset 10 it drives OP2,OP3 on both D[0:15] and D[16:31] (1111).
- R4: On a 32-bit port, a word at offset 00 drives OP0..OP3 on all four lanes in one transaction.
- R5: On a 16-bit port (`req_port16`=1), a byte at an even offset goes on D[0:7] (1000) and a byte at an odd offset goes on D[8:15] (0100). A halfword goes on D[0:15] (1100).
- R6: With `bus16_mode`=1, every request follows the 16-bit port rules, whatever `req_port16` is.
- R7: A word written to a 16-bit port becomes two transactions. The first carries OP0,OP1 on D[0:15] with `ext_addr_lo`=00. The second starts on the cycle after the first one's `ext_done` and carries OP2,OP3 on D[0:15] with `ext_addr_lo`=10.
- R8: `ext_atomic` is high from the first cycle of the first half of a split word until the second half completes, and it is low otherwise.
- R9: A lane whose enable is low carries zero data.
- R10: `req_ready` is low while `ext_valid` is high. While `ext_done` is low, `ext_valid`, `ext_data`, `ext_lane_en` and `ext_addr_lo` hold their values. A single transaction ends on the cycle after `ext_done`.
- R11: After reset, `ext_valid`, `ext_atomic`, `req_illegal` and `ext_lane_en` are low and `req_ready` is high.
- R12: For a transaction that is not split, `ext_addr_lo` equals the request's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus16_mode | input | 1 | Forces 16-bit port rules on every request |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_size | input | 2 | Size code: 01 byte, 10 halfword, 00 word |
| req_off | input | 2 | Address bits A30 (bit 1) and A31 (bit 0) |
| req_data | input | 32 | Write word, OP0 in the top byte |
| req_port16 | input | 1 | Target port is 16 bits wide |
| req_illegal | output | 1 | One-cycle pulse when a request is rejected |
| ext_valid | output | 1 | External transaction in progress |
| ext_done | input | 1 | Current external transaction completes |
| ext_data | output | 32 | External data lanes |
| ext_lane_en | output | 4 | Per-lane drive enable, bit 3 = D[0:7] |
| ext_addr_lo | output | 2 | A30/A31 for the current transaction |
| ext_atomic | output | 1 | Split word in progress; bus must not be released |

## Verification
The bench builds the block with its default lane width of 8 bits. This is the width at which the four-lane tables are defined, so every byte, halfword and word pattern on both port widths can be reached from one word with distinct operand bytes. Holding `ext_done` low for several cycles in the middle of a split word shows that the data stays stable and that the atomic flag is not released between the halves. Back-to-back illegal requests show that `req_ready` never drops for them.

// File: rtl/wls_pkg.sv
package wls_pkg;
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SINGLE = 2'b01,
    ST_FIRST  = 2'b10,
    ST_SECOND = 2'b11
  } wls_state_e;
endpackage

// File: rtl/wls_decode.sv
module wls_decode
  import wls_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [1:0]          size,
  input  logic [1:0]          off,
  input  logic [4*LANE_W-1:0] word,
  input  logic                p16,
  output logic [3:0]          lane_en,
  output logic [4*LANE_W-1:0] lane_data,
  output logic                split,
  output logic                illegal
);
  localparam int LANES = 4;

  logic [1:0] src [LANES];

  always_comb begin
    lane_en = '0;
    split   = 1'b0;
    illegal = 1'b0;
    for (int j = 0; j < LANES; j++) src[j] = 2'd0;
    unique case (size)
      SZ_BYTE: begin
        if (p16) begin
          if (off[0]) begin lane_en[2] = 1'b1; src[2] = off; end
          else        begin lane_en[3] = 1'b1; src[3] = off; end
        end else begin
          lane_en[3] = 1'b1;        src[3] = off;
          lane_en[2] = off[0];      src[2] = off;
          lane_en[1] = (off == 2'b10); src[1] = 2'd2;
          lane_en[0] = (off == 2'b11); src[0] = 2'd3;
        end
      end
      SZ_HALF: begin
        if (off[0]) illegal = 1'b1;
        else begin
          lane_en[3:2] = 2'b11;
          src[3] = {off[1], 1'b0};
          src[2] = {off[1], 1'b1};
          if (!p16 && off[1]) begin
            lane_en[1:0] = 2'b11;
            src[1] = 2'd2;
            src[0] = 2'd3;
          end
        end
      end
      SZ_WORD: begin
        if (off != 2'b00) illegal = 1'b1;
        else if (p16) begin
          split = 1'b1;
          lane_en[3:2] = 2'b11;
          src[3] = 2'd0;
          src[2] = 2'd1;
        end else begin
          lane_en = 4'b1111;
          for (int j = 0; j < LANES; j++) src[j] = 2'(LANES - 1 - j);
        end
      end
      default: illegal = 1'b1;
    endcase
  end

  // lane j (j = 3 is the most significant lane) picks operand src[j]
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < LANES; k++)
        if (src[j] == 2'(k)) pick = word[(LANES-1-k)*LANE_W +: LANE_W];
    end
    assign lane_data[j*LANE_W +: LANE_W] = lane_en[j] ? pick : '0;
  end
endmodule

// File: rtl/wls_seq.sv
module wls_seq
  import wls_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_off,
  input  logic [2*LANE_W-1:0] req_low_half,
  input  logic [3:0]          dec_en,
  input  logic [4*LANE_W-1:0] dec_data,
  input  logic                dec_split,
  input  logic                dec_illegal,
  input  logic                ext_done,
  output logic                ext_valid,
  output logic [4*LANE_W-1:0] ext_data,
  output logic [3:0]          ext_lane_en,
  output logic [1:0]          ext_addr_lo,
  output logic                ext_atomic,
  output logic                req_illegal
);
  localparam int BUS_W = 4 * LANE_W;

  wls_state_e          state;
  logic [2*LANE_W-1:0] hi_q;
  logic                accept;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign ext_valid  = (state != ST_IDLE);
  assign ext_atomic = (state == ST_FIRST) || (state == ST_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      hi_q        <= '0;
      ext_data    <= '0;
      ext_lane_en <= '0;
      ext_addr_lo <= '0;
      req_illegal <= 1'b0;
    end else begin
      req_illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_illegal) begin
              req_illegal <= 1'b1;
            end else begin
              ext_data    <= dec_data;
              ext_lane_en <= dec_en;
              ext_addr_lo <= dec_split ? 2'b00 : req_off;
              hi_q        <= req_low_half;
              state       <= dec_split ? ST_FIRST : ST_SINGLE;
            end
          end
        end
        ST_FIRST: begin
          if (ext_done) begin
            ext_data    <= {hi_q, {(BUS_W/2){1'b0}}};
            ext_lane_en <= 4'b1100;
            ext_addr_lo <= 2'b10;
            state       <= ST_SECOND;
          end
        end
        default: begin
          if (ext_done) begin
            ext_data    <= '0;
            ext_lane_en <= '0;
            state       <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid && !ext_done |=> ext_valid && $stable(ext_data) && $stable(ext_lane_en) && $stable(ext_addr_lo)); // R10
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> !req_ready); // R10
  AST_ILLEGAL_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    req_illegal |-> !ext_valid && req_ready); // R1
  AST_SPLIT_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_atomic && ext_done && !ext_addr_lo[1] |=> ext_atomic && ext_valid && ext_addr_lo[1]); // R7
  AST_ATOMIC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_atomic && ext_done && ext_addr_lo[1] |=> !ext_atomic && !ext_valid); // R8
endmodule

// File: rtl/wr_lane_steer.sv
module wr_lane_steer
  import wls_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus16_mode,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_size,
  input  logic [1:0]          req_off,
  input  logic [4*LANE_W-1:0] req_data,
  input  logic                req_port16,
  output logic                req_illegal,
  output logic                ext_valid,
  input  logic                ext_done,
  output logic [4*LANE_W-1:0] ext_data,
  output logic [3:0]          ext_lane_en,
  output logic [1:0]          ext_addr_lo,
  output logic                ext_atomic
);
  localparam int BUS_W = 4 * LANE_W;

  logic [3:0]       dec_en;
  logic [BUS_W-1:0] dec_data;
  logic             dec_split;
  logic             dec_illegal;

  wls_decode #(.LANE_W(LANE_W)) u_decode (
    .size      (req_size),
    .off       (req_off),
    .word      (req_data),
    .p16       (req_port16 | bus16_mode),
    .lane_en   (dec_en),
    .lane_data (dec_data),
    .split     (dec_split),
    .illegal   (dec_illegal)
  );

  wls_seq #(.LANE_W(LANE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_off      (req_off),
    .req_low_half (req_data[2*LANE_W-1:0]),
    .dec_en       (dec_en),
    .dec_data     (dec_data),
    .dec_split    (dec_split),
    .dec_illegal  (dec_illegal),
    .ext_done     (ext_done),
    .ext_valid    (ext_valid),
    .ext_data     (ext_data),
    .ext_lane_en  (ext_lane_en),
    .ext_addr_lo  (ext_addr_lo),
    .ext_atomic   (ext_atomic),
    .req_illegal  (req_illegal)
  );

  for (genvar j = 0; j < 4; j++) begin : g_chk
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_lane_en[j] |-> ext_data[j*LANE_W +: LANE_W] == '0); // R9
  end
endmodule

// File: tb/wr_lane_steer_tb.sv
module wr_lane_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus16_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'b00;
  logic [1:0]  req_off = 2'b00;
  logic [31:0] req_data = 32'h0;
  logic        req_port16 = 1'b0;
  logic        req_illegal;
  logic        ext_valid;
  logic        ext_done = 1'b0;
  logic [31:0] ext_data;
  logic [3:0]  ext_lane_en;
  logic [1:0]  ext_addr_lo;
  logic        ext_atomic;

  int nchk = 0;
  int nerr = 0;

  localparam logic [31:0] W = 32'hA1B2C3D4;

  always #10 clk = ~clk;

  wr_lane_steer u_dut (
    .clk(clk), .rst_n(rst_n), .bus16_mode(bus16_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
    .req_off(req_off), .req_data(req_data), .req_port16(req_port16),
    .req_illegal(req_illegal), .ext_valid(ext_valid), .ext_done(ext_done),
    .ext_data(ext_data), .ext_lane_en(ext_lane_en), .ext_addr_lo(ext_addr_lo),
    .ext_atomic(ext_atomic)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic [1:0] off,
                       input logic p16, input logic m16);
    @(negedge clk);
    req_valid = 1'b1; req_size = sz; req_off = off; req_data = W;
    req_port16 = p16; bus16_mode = m16;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic single(input string tag, input logic [1:0] sz, input logic [1:0] off,
                        input logic p16, input logic m16,
                        input logic [3:0] een, input logic [31:0] edat);
    drive(sz, off, p16, m16);
    chk({tag, " valid"}, 32'(ext_valid), 32'd1);
    chk({tag, " R10 ready low"}, 32'(req_ready), 32'd0);
    chk({tag, " en"}, 32'(ext_lane_en), 32'(een));
    chk({tag, " data"}, ext_data, edat);
    chk({tag, " R12 addr"}, 32'(ext_addr_lo), 32'(off));
    chk({tag, " R8 atomic low"}, 32'(ext_atomic), 32'd0);
    ext_done = 1'b1;
    @(negedge clk);
    ext_done = 1'b0;
    chk({tag, " R10 ends"}, 32'(ext_valid), 32'd0);
    chk({tag, " R10 ready back"}, 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 valid", 32'(ext_valid), 32'd0);
    chk("R11 ready", 32'(req_ready), 32'd1);
    chk("R11 atomic", 32'(ext_atomic), 32'd0);
    chk("R11 illegal", 32'(req_illegal), 32'd0);
    chk("R11 en", 32'(ext_lane_en), 32'd0);
  endtask

  task automatic t_byte32();
    single("R2 R9 byte00", 2'b01, 2'b00, 1'b0, 1'b0, 4'b1000, 32'hA1000000);
    single("R2 R9 byte01", 2'b01, 2'b01, 1'b0, 1'b0, 4'b1100, 32'hB2B20000);
    single("R2 R9 byte10", 2'b01, 2'b10, 1'b0, 1'b0, 4'b1010, 32'hC300C300);
    single("R2 R9 byte11", 2'b01, 2'b11, 1'b0, 1'b0, 4'b1101, 32'hD4D400D4);
  endtask

  task automatic t_half32();
    single("R3 half00", 2'b10, 2'b00, 1'b0, 1'b0, 4'b1100, 32'hA1B20000);
    single("R3 half10", 2'b10, 2'b10, 1'b0, 1'b0, 4'b1111, 32'hC3D4C3D4);
  endtask

  task automatic t_word32();
    single("R4 word", 2'b00, 2'b00, 1'b0, 1'b0, 4'b1111, 32'hA1B2C3D4);
  endtask

  task automatic t_port16();
    single("R5 byte00", 2'b01, 2'b00, 1'b1, 1'b0, 4'b1000, 32'hA1000000);
    single("R5 byte01", 2'b01, 2'b01, 1'b1, 1'b0, 4'b0100, 32'h00B20000);
    single("R5 byte10", 2'b01, 2'b10, 1'b1, 1'b0, 4'b1000, 32'hC3000000);
    single("R5 byte11", 2'b01, 2'b11, 1'b1, 1'b0, 4'b0100, 32'h00D40000);
    single("R5 half00", 2'b10, 2'b00, 1'b1, 1'b0, 4'b1100, 32'hA1B20000);
    single("R5 half10", 2'b10, 2'b10, 1'b1, 1'b0, 4'b1100, 32'hC3D40000);
  endtask

  task automatic t_mode16();
    single("R6 byte11", 2'b01, 2'b11, 1'b0, 1'b1, 4'b0100, 32'h00D40000);
    single("R6 half10", 2'b10, 2'b10, 1'b0, 1'b1, 4'b1100, 32'hC3D40000);
  endtask

  task automatic t_split(input logic p16, input logic m16);
    drive(2'b00, 2'b00, p16, m16);
    chk("R7 first en", 32'(ext_lane_en), 32'hC);
    chk("R7 first data", ext_data, 32'hA1B20000);
    chk("R7 first addr", 32'(ext_addr_lo), 32'd0);
    chk("R8 atomic first", 32'(ext_atomic), 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 hold data", ext_data, 32'hA1B20000);
    chk("R8 atomic held", 32'(ext_atomic), 32'd1);
    chk("R10 ready low", 32'(req_ready), 32'd0);
    ext_done = 1'b1;
    @(negedge clk);
    ext_done = 1'b0;
    chk("R7 second valid", 32'(ext_valid), 32'd1);
    chk("R7 second en", 32'(ext_lane_en), 32'hC);
    chk("R7 second data", ext_data, 32'hC3D40000);
    chk("R7 second addr", 32'(ext_addr_lo), 32'd2);
    chk("R8 atomic second", 32'(ext_atomic), 32'd1);
    ext_done = 1'b1;
    @(negedge clk);
    ext_done = 1'b0;
    chk("R8 atomic released", 32'(ext_atomic), 32'd0);
    chk("R7 done", 32'(ext_valid), 32'd0);
  endtask

  task automatic t_illegal(input string tag, input logic [1:0] sz, input logic [1:0] off);
    drive(sz, off, 1'b0, 1'b0);
    chk({tag, " R1 flag"}, 32'(req_illegal), 32'd1);
    chk({tag, " R1 no xfer"}, 32'(ext_valid), 32'd0);
    chk({tag, " R1 ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    chk({tag, " R1 pulse"}, 32'(req_illegal), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte32();
    t_half32();
    t_word32();
    t_port16();
    t_mode16();
    t_split(1'b1, 1'b0);
    t_split(1'b0, 1'b1);
    t_illegal("size11", 2'b11, 2'b00);
    t_illegal("half01", 2'b10, 2'b01);
    t_illegal("half11", 2'b10, 2'b11);
    t_illegal("word10", 2'b00, 2'b10);
    t_illegal("word01", 2'b00, 2'b01);
    single("R1 after illegal", 2'b01, 2'b00, 1'b0, 1'b0, 4'b1000, 32'hA1000000);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule